// File: doc/BRIEF.md
# Segmented Register-Space Address Decoder

This block sits behind a single user-side register bus and gives each kind of engine its own address range. A 17-bit word address is cut into three fields: a segment for the core type, a slot inside the segment, and a register index inside the slot. The hash segment holds a row of core slots. Its slot 0 is not a core. It is a small bank of board-wide registers: two read-only identifiers and one scratch register. The random-number and cipher segments currently hold only placeholder registers, so the upper address bits can be checked from software before real engines exist.

Write and read strobes for an attached hash core go out on per-slot strobe pins. The register index and the write data are broadcast to all cores. Each core returns read data combinationally. The decoder registers the selected word and presents it one clock after the read strobe, with a matching valid pulse. Unmapped writes are dropped and unmapped reads return zero. A parameter mask removes any core slot, and a removed slot decodes as unmapped. The bus has no back-pressure: strobes are single-cycle pulses that are always accepted, and read data is never stalled.

Top module: `regspace_decoder`

## Requirements
- R1: The address fields are: bits [16:14] select the segment (0 = hash, 1 = random-number, 2 = cipher, 3 to 7 unmapped), bits [13:8] select the slot, and bits [7:0] select the register word. A write to one segment never changes a register in another segment.
- R2: A write to hash slot k (1 to HASH_CORES) whose core is enabled pulses `hs_wr[k-1]` in the same cycle. A read to such a slot pulses `hs_rd[k-1]` in the same cycle. In both cases `hs_addr` carries bits [7:0] of the address and `hs_wdata` carries the write data. At most one strobe bit is high in any cycle.
- R3: After a read strobe in cycle t, `rdata` holds the selected word and `rd_valid` is high in cycle t+1. `rd_valid` is low after any cycle with no read strobe.
- R4: In hash slot 0, register 0 reads the BOARD_ID parameter and register 1 reads BUILD_VER. Both are read-only, and writes to them are ignored. Register 2 is a read/write scratch word.
- R5: In slot 0 of the random-number segment and in slot 0 of the cipher segment, register 0 reads a fixed identifier (RNG_ID or CIPHER_ID) and register 1 is a read/write scratch word.
- R6: A write to an unmapped location raises no strobe and changes no register. Unmapped locations are segments 3 to 7, slots above HASH_CORES, nonzero slots of the random-number and cipher segments, and unused register indices in the internal banks. A read from an unmapped location returns zero.
- R7: A hash slot whose bit in CORE_EN is 0 never receives a strobe, and reads from it return zero.
- R8: While reset is held, `rdata` is zero, `rd_valid` is low, and every scratch register is cleared to zero.
- R9: A read of an enabled hash slot returns the value the core drives on its `hs_rdata` lane during the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 17 | Word address (segment, slot, register) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read strobe |
| hs_wr | output | HASH_CORES | Per-core write strobe (bit k is slot k+1) |
| hs_rd | output | HASH_CORES | Per-core read strobe |
| hs_addr | output | 8 | Register index broadcast to cores |
| hs_wdata | output | 32 | Write data broadcast to cores |
| hs_rdata | input | 32*HASH_CORES | Combinational read data, one 32-bit lane per core |

## Verification
The assertions check on every cycle that the read-data stage takes exactly one clock, that the core strobes are one-hot and follow the bus strobes, and that an unmapped read leaves zero in `rdata`. They also check that a scratch register changes only when a write targets it. Other behaviour can be shown only by the bench's scenarios. This includes the address-field split, the identifier values, writes to read-only words being ignored, and isolation between segments. It also includes a parameter-disabled slot decoding as unmapped and the scratch registers clearing on a reset in the middle of a run.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
  localparam int ADDR_W = 17;
  localparam int SEG_W  = 3;
  localparam int SLOT_W = 6;
  localparam int REG_W  = 8;
  localparam int DATA_W = 32;

  typedef enum logic [SEG_W-1:0] {
    SEG_HASH   = 3'd0,
    SEG_RNG    = 3'd1,
    SEG_CIPHER = 3'd2
  } seg_e;

  typedef struct packed {
    logic [SEG_W-1:0]  seg;
    logic [SLOT_W-1:0] slot;
    logic [REG_W-1:0]  idx;
  } waddr_t;
endpackage

// File: rtl/regdec_select.sv
module regdec_select
  import regdec_pkg::*;
#(
  parameter int                   HASH_CORES = 3,
  parameter logic [HASH_CORES-1:0] CORE_EN   = '1
) (
  input  waddr_t                 a,
  output logic                   hit_glb,
  output logic                   hit_rng,
  output logic                   hit_cph,
  output logic [HASH_CORES-1:0]  hit_core,
  output logic                   hit_none
);
  logic slot_zero;
  assign slot_zero = (a.slot == '0);

  assign hit_glb = (a.seg == SEG_HASH)   && slot_zero;
  assign hit_rng = (a.seg == SEG_RNG)    && slot_zero;
  assign hit_cph = (a.seg == SEG_CIPHER) && slot_zero;

  // Core k lives in hash slot k+1; a masked core simply never matches.
  for (genvar k = 0; k < HASH_CORES; k++) begin : g_core
    if (CORE_EN[k]) begin : g_on
      assign hit_core[k] = (a.seg == SEG_HASH) && (a.slot == SLOT_W'(k + 1));
    end else begin : g_off
      assign hit_core[k] = 1'b0;
    end
  end

  assign hit_none = !(hit_glb || hit_rng || hit_cph || (|hit_core));
endmodule

// File: rtl/regdec_regbank.sv
module regdec_regbank
  import regdec_pkg::*;
#(
  parameter int                   NUM_RO = 1,
  parameter logic [NUM_RO*32-1:0] RO_VALS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [REG_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);
  localparam logic [REG_W-1:0] SCR_IDX = REG_W'(NUM_RO);

  logic [DATA_W-1:0] scratch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            scratch <= '0;
    else if (sel && we && idx == SCR_IDX)  scratch <= wdata;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RO; i++)
      if (idx == REG_W'(i)) rd_val = RO_VALS[i*32 +: 32];
    if (idx == SCR_IDX) rd_val = scratch;
  end

  // R4 / R5 / R6: the scratch word moves only after a write aimed at this bank.
  assert_scratch_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scratch) |-> $past(sel && we));
endmodule

// File: rtl/regspace_decoder.sv
module regspace_decoder
  import regdec_pkg::*;
#(
  parameter int                    HASH_CORES = 3,
  parameter logic [HASH_CORES-1:0] CORE_EN    = 3'b101,
  parameter logic [31:0]           BOARD_ID   = 32'h5EC0_0B0A,
  parameter logic [31:0]           BUILD_VER  = 32'h0002_0015,
  parameter logic [31:0]           RNG_ID     = 32'h0000_52AE,
  parameter logic [31:0]           CIPHER_ID  = 32'h0000_C1F0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rd_valid,
  output logic [HASH_CORES-1:0]        hs_wr,
  output logic [HASH_CORES-1:0]        hs_rd,
  output logic [REG_W-1:0]             hs_addr,
  output logic [DATA_W-1:0]            hs_wdata,
  input  logic [HASH_CORES*DATA_W-1:0] hs_rdata
);
  waddr_t                  a;
  logic                    hit_glb, hit_rng, hit_cph, hit_none;
  logic [HASH_CORES-1:0]   hit_core;
  logic [DATA_W-1:0]       glb_val, rng_val, cph_val, sel_data;

  assign a = addr;

  regdec_select #(.HASH_CORES(HASH_CORES), .CORE_EN(CORE_EN)) u_sel (
    .a(a), .hit_glb(hit_glb), .hit_rng(hit_rng), .hit_cph(hit_cph),
    .hit_core(hit_core), .hit_none(hit_none)
  );

  regdec_regbank #(.NUM_RO(2), .RO_VALS({BUILD_VER, BOARD_ID})) u_glb (
    .clk(clk), .rst_n(rst_n), .sel(hit_glb), .we(wr_en),
    .idx(a.idx), .wdata(wdata), .rd_val(glb_val)
  );

  regdec_regbank #(.NUM_RO(1), .RO_VALS(RNG_ID)) u_rng (
    .clk(clk), .rst_n(rst_n), .sel(hit_rng), .we(wr_en),
    .idx(a.idx), .wdata(wdata), .rd_val(rng_val)
  );

  regdec_regbank #(.NUM_RO(1), .RO_VALS(CIPHER_ID)) u_cph (
    .clk(clk), .rst_n(rst_n), .sel(hit_cph), .we(wr_en),
    .idx(a.idx), .wdata(wdata), .rd_val(cph_val)
  );

  assign hs_wr    = {HASH_CORES{wr_en}} & hit_core;
  assign hs_rd    = {HASH_CORES{rd_en}} & hit_core;
  assign hs_addr  = a.idx;
  assign hs_wdata = wdata;

  // AND-OR read mux: every unselected source contributes zero.
  always_comb begin
    sel_data = ({DATA_W{hit_glb}} & glb_val)
             | ({DATA_W{hit_rng}} & rng_val)
             | ({DATA_W{hit_cph}} & cph_val);
    for (int k = 0; k < HASH_CORES; k++)
      sel_data |= {DATA_W{hit_core[k]}} & hs_rdata[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel_data;
    end
  end

  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hs_wr) |-> (wr_en && $onehot0(hs_wr)));
  assert_rd_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hs_rd) |-> (rd_en && $onehot0(hs_rd)));
  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_none) |=> (rdata == '0));
endmodule

// File: tb/regspace_decoder_tb.sv
module regspace_decoder_tb_top;
  localparam int          NC    = 3;
  localparam logic [31:0] B_ID  = 32'h5EC0_0B0A;
  localparam logic [31:0] B_VER = 32'h0002_0015;
  localparam logic [31:0] R_ID  = 32'h0000_52AE;
  localparam logic [31:0] C_ID  = 32'h0000_C1F0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [16:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rd_valid;
  logic [NC-1:0]     hs_wr, hs_rd;
  logic [7:0]        hs_addr;
  logic [31:0]       hs_wdata;
  logic [NC*32-1:0]  hs_rdata;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  regspace_decoder #(.HASH_CORES(NC), .CORE_EN(3'b101), .BOARD_ID(B_ID),
    .BUILD_VER(B_VER), .RNG_ID(R_ID), .CIPHER_ID(C_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .hs_wr(hs_wr),
    .hs_rd(hs_rd), .hs_addr(hs_addr), .hs_wdata(hs_wdata), .hs_rdata(hs_rdata)
  );

  // Register-file stand-ins for the hash cores: four words each, combinational read.
  logic [31:0] stub_q [NC][4];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NC; k++)
        for (int i = 0; i < 4; i++) stub_q[k][i] <= 32'hC0DE_0000 + 32'(k*16 + i);
    end else begin
      for (int k = 0; k < NC; k++)
        if (hs_wr[k]) stub_q[k][hs_addr[1:0]] <= hs_wdata;
    end
  end
  always_comb
    for (int k = 0; k < NC; k++) hs_rdata[k*32 +: 32] = stub_q[k][hs_addr[1:0]];

  function automatic logic [16:0] mk(int seg, int slot, int idx);
    return {3'(seg), 6'(slot), 8'(idx)};
  endfunction

  typedef struct packed {
    logic        rd;
    logic [16:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, mk(0,0,0), 32'h0, B_ID,          4'd4},  // R4 board id
    '{1'b1, mk(0,0,1), 32'h0, B_VER,         4'd4},  // R4 version
    '{1'b1, mk(0,0,2), 32'h0, 32'h0,         4'd8},  // R8 scratch after reset
    '{1'b0, mk(0,0,2), 32'hA5A5_0001, 32'h0, 4'd4},
    '{1'b1, mk(0,0,2), 32'h0, 32'hA5A5_0001, 4'd4},  // R4 scratch RW
    '{1'b0, mk(0,0,0), 32'hFFFF_FFFF, 32'h0, 4'd4},
    '{1'b1, mk(0,0,0), 32'h0, B_ID,          4'd4},  // R4 RO ignores write
    '{1'b1, mk(1,0,0), 32'h0, R_ID,          4'd5},  // R5 rng id
    '{1'b0, mk(1,0,1), 32'h1111_2222, 32'h0, 4'd5},
    '{1'b1, mk(1,0,1), 32'h0, 32'h1111_2222, 4'd5},  // R5 rng scratch
    '{1'b1, mk(2,0,0), 32'h0, C_ID,          4'd5},  // R5 cipher id
    '{1'b0, mk(2,0,1), 32'h3333_4444, 32'h0, 4'd5},
    '{1'b1, mk(2,0,1), 32'h0, 32'h3333_4444, 4'd5},  // R5 cipher scratch
    '{1'b1, mk(1,0,1), 32'h0, 32'h1111_2222, 4'd1},  // R1 segments isolated
    '{1'b0, mk(5,0,1), 32'hDEAD_0000, 32'h0, 4'd6},
    '{1'b1, mk(2,0,1), 32'h0, 32'h3333_4444, 4'd6},  // R6 unmapped write dropped
    '{1'b1, mk(5,0,1), 32'h0, 32'h0,         4'd6},  // R6 unmapped segment
    '{1'b1, mk(0,1,0), 32'h0, 32'hC0DE_0000, 4'd9},  // R9 core 0 lane
    '{1'b1, mk(0,3,1), 32'h0, 32'hC0DE_0021, 4'd9},  // R9 core 2 lane
    '{1'b1, mk(0,2,0), 32'h0, 32'h0,         4'd7},  // R7 masked slot
    '{1'b1, mk(0,9,0), 32'h0, 32'h0,         4'd6},  // R6 slot above range
    '{1'b1, mk(1,1,1), 32'h0, 32'h0,         4'd6}   // R6 nonzero rng slot
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [16:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [16:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R8 rdata in reset", rdata, 32'h0);
    check("R8 rd_valid in reset", 32'(rd_valid), 32'h0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      if (VECS[i].rd) begin
        do_rd(VECS[i].a, v);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
      end else begin
        do_wr(VECS[i].a, VECS[i].d);
      end
    end

    // R2: write strobe routing and broadcast fields, same cycle
    @(negedge clk); addr = mk(0,1,2); wdata = 32'h0BAD_F00D; wr_en = 1'b1;
    #1;
    check("R2 hs_wr", 32'(hs_wr), 32'h1);
    check("R2 hs_addr", 32'(hs_addr), 32'h2);
    check("R2 hs_wdata", hs_wdata, 32'h0BAD_F00D);
    @(negedge clk); wr_en = 1'b0;
    do_rd(mk(0,1,2), v);
    check("R2 core write landed", v, 32'h0BAD_F00D);

    // R2: read strobe for slot 3
    @(negedge clk); addr = mk(0,3,0); rd_en = 1'b1;
    #1; check("R2 hs_rd", 32'(hs_rd), 32'h4);
    @(negedge clk); rd_en = 1'b0;
    check("R3 rd_valid after read", 32'(rd_valid), 32'h1);
    check("R3 rdata after read", rdata, 32'hC0DE_0020);
    @(negedge clk);
    check("R3 rd_valid idle", 32'(rd_valid), 32'h0);

    // R7: masked slot gets no strobe
    @(negedge clk); addr = mk(0,2,0); wdata = 32'h1; wr_en = 1'b1;
    #1; check("R7 no strobe on masked slot", 32'(hs_wr), 32'h0);
    @(negedge clk); wr_en = 1'b0;

    // R6: unmapped segment gets no strobe; unused bank index ignored
    @(negedge clk); addr = mk(6,1,0); wr_en = 1'b1;
    #1; check("R6 no strobe unmapped", 32'(hs_wr), 32'h0);
    @(negedge clk); wr_en = 1'b0;
    do_wr(mk(0,0,7), 32'h7777_7777);
    do_rd(mk(0,0,7), v);
    check("R6 unused index reads zero", v, 32'h0);
    do_rd(mk(0,0,2), v);
    check("R6 scratch untouched", v, 32'hA5A5_0001);

    // R8: reset mid-run clears scratch words
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 rdata cleared", rdata, 32'h0);
    rst_n = 1'b1;
    do_rd(mk(0,0,2), v);
    check("R8 global scratch cleared", v, 32'h0);
    do_rd(mk(2,0,1), v);
    check("R8 cipher scratch cleared", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule